// File: doc/BRIEF.md
# Gated Frequency Meter with Multiplexed Decimal Display

This block measures the frequency of a free-running digital signal by counting its rising edges during a fixed gate window. The window is timed by the reference clock: it lasts `REF_HZ / RES_HZ` reference cycles. The count, in decimal, therefore equals the signal frequency divided by the resolution. The edges are counted in the signal's own clock domain by a chain of decade counters, one decade per display digit, so a fast input needs no prescaler. After each gate, a toggle handshake returns the snapshot to the reference domain. There, a constant BCD offset is added. With this offset the display can show an operating frequency instead of the bare oscillator frequency.

The corrected value is held in a result register that changes only once per completed gate. From this register a scanner drives time-multiplexed seven-segment digits and blanks the leading zeros. The scan rate is set apart from the gate period, so a fine resolution never slows the scan or makes it flicker.

A small controller in the reference domain sequences each measurement. **IDLE** is the state after reset. **OPEN** holds the gate high. **WAIT** keeps the gate closed until the signal domain returns its snapshot, or until a time limit expires. **LATCH** publishes the reading. The transitions are:
- IDLE→OPEN, unconditional.
- OPEN→WAIT, when the window count is reached.
- WAIT→LATCH, on a handshake toggle or on timeout.
- LATCH→OPEN, unconditional.

Top module: `fc_freq_meter`

## Requirements
- R1: Each gate window keeps the internal gate high for exactly `GATE_CYC = REF_HZ/RES_HZ` reference cycles. The raw count is the number of `sig_in` rising edges inside that window, which is f_sig / RES_HZ.
- R2: `result_bcd` holds the reading as BCD, with digit i in bits [4i+3:4i]. It changes only in a cycle where `upd` is high, and `upd` is a single-cycle pulse once per completed gate.
- R3: The BCD value on `offset_bcd` (same digit layout) is added to the raw count. `result_bcd` shows (count + offset) mod 10^NDIG.
- R4: `ovf` is high with a reading when the raw count reached 10^NDIG (the top decade carried out) or when the offset sum carried out. Otherwise it is low, and it changes only with `upd`.
- R5: If `sig_in` has no edges, each gate ends after `WAIT_CYC` closed cycles, and the reading equals the offset with `ovf` low.
- R6: `dig_sel` is one-hot and active high. Digit 0 is selected first after reset. Each digit is selected for `SCAN_DIV = REF_HZ/SCAN_HZ` cycles, then the next one, and the scan wraps after digit NDIG-1.
- R7: `seg` is {g,f,e,d,c,b,a}, active high. Digits 0..9 encode as 3F,06,5B,4F,66,6D,7D,07,7F,6F (hex).
- R8: When digit i>0 is selected and that digit and every higher digit of `result_bcd` are zero, `seg` is 00. Digit 0 is never blanked.
- R9: During reset, `result_bcd`=0, `ovf`=0, `upd`=0 and `dig_sel` selects digit 0.
- R10: Successive `upd` pulses are between GATE_CYC+2 and GATE_CYC+WAIT_CYC+1 cycles apart. The gate stays closed for at most WAIT_CYC+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; sets the gate and the scan timing |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sig_in | input | 1 | Signal under test; its rising edges are counted |
| offset_bcd | input | NDIG*4 | Constant BCD correction added to each reading |
| seg | output | 7 | Segment drive {g,f,e,d,c,b,a}, active high |
| dig_sel | output | NDIG | One-hot digit enable, active high |
| result_bcd | output | NDIG*4 | Latched BCD reading |
| ovf | output | 1 | Overflow flag of the latched reading |
| upd | output | 1 | One-cycle pulse when a new reading is latched |

## Verification
The assertions assume that `sig_in` delivers its snapshot within the WAIT_CYC limit. They also assume that `offset_bcd` holds valid BCD and stays stable across a latch. The stimulus meets both conditions. Signal periods range from 2 to 400 time units against a 10-unit reference period. Every rising edge of `sig_in` falls on an even time, while every reference edge falls on an odd time, so no sample is ambiguous. The gate length is an exact multiple of each signal period, which makes every count exact. Offsets are changed only together with a period change, and the two readings that follow any change are discarded.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic [1:0] {
        GS_IDLE,
        GS_OPEN,
        GS_WAIT,
        GS_LATCH
    } gate_state_t;

    // Segment pattern {g,f,e,d,c,b,a}, active high.
    function automatic logic [6:0] seg_of(input logic [3:0] d);
        logic [6:0] s;
        case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fc_edge_counter.sv
// Counts sig_clk rising edges while the synchronised gate is high.
// Snapshots the count when the gate closes and flips a toggle.
module fc_edge_counter #(
    parameter int NDIG = 6
) (
    input  logic              sig_clk,
    input  logic              rst_n,
    input  logic              gate_i,
    output logic [NDIG*4-1:0] hold_o,
    output logic              hold_ovf_o,
    output logic              tog_o
);

    logic                   g_meta, g_sync, g_prev;
    logic [NDIG-1:0][3:0]   dig_q, dig_nx, hold_q;
    logic [NDIG:0]          carry;
    logic                   run_ovf, hold_ovf_q, tog_q;

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < NDIG; i++) begin : g_decade
        assign carry[i+1] = carry[i] && (dig_q[i] == 4'd9);
        assign dig_nx[i]  = !carry[i]          ? dig_q[i] :
                            (dig_q[i] == 4'd9) ? 4'd0     : dig_q[i] + 4'd1;
    end

    always_ff @(posedge sig_clk or negedge rst_n) begin
        if (!rst_n) begin
            g_meta     <= 1'b0;
            g_sync     <= 1'b0;
            g_prev     <= 1'b0;
            dig_q      <= '0;
            run_ovf    <= 1'b0;
            hold_q     <= '0;
            hold_ovf_q <= 1'b0;
            tog_q      <= 1'b0;
        end else begin
            g_meta <= gate_i;
            g_sync <= g_meta;
            g_prev <= g_sync;
            if (g_sync) begin
                dig_q   <= dig_nx;
                run_ovf <= run_ovf | carry[NDIG];
            end else begin
                dig_q   <= '0;
                run_ovf <= 1'b0;
            end
            if (g_prev && !g_sync) begin
                hold_q     <= dig_q;
                hold_ovf_q <= run_ovf;
                tog_q      <= ~tog_q;
            end
        end
    end

    assign hold_o     = hold_q;
    assign hold_ovf_o = hold_ovf_q;
    assign tog_o      = tog_q;

endmodule

// File: rtl/fc_bcd_adder.sv
// Ripple BCD adder, one decade per digit.
module fc_bcd_adder #(
    parameter int NDIG = 6
) (
    input  logic [NDIG*4-1:0] a_i,
    input  logic [NDIG*4-1:0] b_i,
    output logic [NDIG*4-1:0] sum_o,
    output logic              cout_o
);

    logic [NDIG:0] c;
    assign c[0] = 1'b0;

    for (genvar i = 0; i < NDIG; i++) begin : g_digit
        logic [4:0] raw;
        assign raw = {1'b0, a_i[4*i +: 4]} + {1'b0, b_i[4*i +: 4]} + {4'd0, c[i]};
        assign c[i+1] = (raw > 5'd9);
        assign sum_o[4*i +: 4] = c[i+1] ? 4'(raw - 5'd10) : raw[3:0];
    end

    assign cout_o = c[NDIG];

endmodule

// File: rtl/fc_gate_ctrl.sv
// Reference-domain measurement sequencer: opens the gate, waits for the
// snapshot handshake (or times out) and requests a latch.
module fc_gate_ctrl
    import fc_pkg::*;
#(
    parameter int NDIG     = 6,
    parameter int GATE_CYC = 10000,
    parameter int WAIT_CYC = 1250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_tog_i,
    input  logic [NDIG*4-1:0] hold_i,
    input  logic              hold_ovf_i,
    output logic              gate_o,
    output logic [NDIG*4-1:0] snap_o,
    output logic              snap_ovf_o,
    output logic              latch_o
);

    localparam int MAXC  = (GATE_CYC > WAIT_CYC) ? GATE_CYC : WAIT_CYC;
    localparam int CNT_W = $clog2(MAXC) + 1;

    gate_state_t        state, state_nxt;
    logic [CNT_W-1:0]   cyc_q;
    logic               ack_m, ack_s, ack_seen;
    logic               ack_hit, win_done, wait_done;
    logic               gate_q;
    logic [NDIG*4-1:0]  snap_q;
    logic               snap_ovf_q;

    assign ack_hit   = (ack_s != ack_seen);
    assign win_done  = (cyc_q == CNT_W'(GATE_CYC - 1));
    assign wait_done = (cyc_q == CNT_W'(WAIT_CYC - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GS_IDLE;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            GS_IDLE:  state_nxt = GS_OPEN;
            GS_OPEN:  if (win_done) state_nxt = GS_WAIT;
            GS_WAIT:  if (ack_hit || wait_done) state_nxt = GS_LATCH;
            GS_LATCH: state_nxt = GS_OPEN;
        endcase
    end

    // Outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q      <= '0;
            gate_q     <= 1'b0;
            ack_m      <= 1'b0;
            ack_s      <= 1'b0;
            ack_seen   <= 1'b0;
            snap_q     <= '0;
            snap_ovf_q <= 1'b0;
        end else begin
            ack_m  <= ack_tog_i;
            ack_s  <= ack_m;
            cyc_q  <= (state_nxt != state) ? '0 : cyc_q + 1'b1;
            gate_q <= (state_nxt == GS_OPEN);
            // Discard stale toggles: only toggles after the gate closes count.
            if (state == GS_OPEN && state_nxt == GS_WAIT)
                ack_seen <= ack_s;
            if (state == GS_WAIT) begin
                if (ack_hit) begin
                    snap_q     <= hold_i;
                    snap_ovf_q <= hold_ovf_i;
                    ack_seen   <= ack_s;
                end else if (wait_done) begin
                    snap_q     <= '0;
                    snap_ovf_q <= 1'b0;
                end
            end
        end
    end

    assign gate_o     = gate_q;
    assign snap_o     = snap_q;
    assign snap_ovf_o = snap_ovf_q;
    assign latch_o    = (state == GS_LATCH);

endmodule

// File: rtl/fc_scan_display.sv
// Time-multiplexed seven-segment scanner with leading-zero blanking.
module fc_scan_display
    import fc_pkg::*;
#(
    parameter int NDIG     = 6,
    parameter int SCAN_DIV = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NDIG*4-1:0] value_i,
    output logic [6:0]        seg_o,
    output logic [NDIG-1:0]   dig_sel_o
);

    localparam int IDX_W = (NDIG > 1) ? $clog2(NDIG) : 1;
    localparam int SC_W  = $clog2(SCAN_DIV + 1);

    logic [SC_W-1:0]  tick_q;
    logic [IDX_W-1:0] idx_q;
    logic [NDIG-1:0]  lead;
    logic [3:0]       cur;
    logic             blank;

    for (genvar i = 0; i < NDIG; i++) begin : g_lead
        if (i == NDIG - 1) begin : g_top
            assign lead[i] = (value_i[4*i +: 4] == 4'd0);
        end else begin : g_low
            assign lead[i] = (value_i[4*i +: 4] == 4'd0) && lead[i+1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            idx_q  <= '0;
        end else if (tick_q == SC_W'(SCAN_DIV - 1)) begin
            tick_q <= '0;
            idx_q  <= (idx_q == IDX_W'(NDIG - 1)) ? '0 : idx_q + 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    always_comb begin
        cur       = value_i[int'(idx_q)*4 +: 4];
        blank     = (idx_q != '0) && lead[idx_q];
        seg_o     = blank ? 7'h00 : seg_of(cur);
        dig_sel_o = NDIG'(1) << idx_q;
    end

endmodule

// File: rtl/fc_freq_meter.sv
module fc_freq_meter #(
    parameter int NDIG    = 6,
    parameter int REF_HZ  = 1_000_000,
    parameter int RES_HZ  = 100,
    parameter int SCAN_HZ = 10_000
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              sig_in,
    input  logic [NDIG*4-1:0] offset_bcd,
    output logic [6:0]        seg,
    output logic [NDIG-1:0]   dig_sel,
    output logic [NDIG*4-1:0] result_bcd,
    output logic              ovf,
    output logic              upd
);

    localparam int GATE_CYC = REF_HZ / RES_HZ;
    localparam int WAIT_CYC = (GATE_CYC / 8 < 4) ? 4 : GATE_CYC / 8;
    localparam int SCAN_DIV = REF_HZ / SCAN_HZ;
    localparam int DW       = NDIG * 4;

    logic          gate_w, tog_w, hold_ovf_w, snap_ovf_w, latch_w, carry_w;
    logic [DW-1:0] hold_w, snap_w, sum_w;
    logic [DW-1:0] result_q;
    logic          ovf_q, upd_q;

    fc_edge_counter #(.NDIG(NDIG)) u_count (
        .sig_clk    (sig_in),
        .rst_n      (rst_n),
        .gate_i     (gate_w),
        .hold_o     (hold_w),
        .hold_ovf_o (hold_ovf_w),
        .tog_o      (tog_w)
    );

    fc_gate_ctrl #(.NDIG(NDIG), .GATE_CYC(GATE_CYC), .WAIT_CYC(WAIT_CYC)) u_ctrl (
        .clk        (ref_clk),
        .rst_n      (rst_n),
        .ack_tog_i  (tog_w),
        .hold_i     (hold_w),
        .hold_ovf_i (hold_ovf_w),
        .gate_o     (gate_w),
        .snap_o     (snap_w),
        .snap_ovf_o (snap_ovf_w),
        .latch_o    (latch_w)
    );

    fc_bcd_adder #(.NDIG(NDIG)) u_add (
        .a_i    (snap_w),
        .b_i    (offset_bcd),
        .sum_o  (sum_w),
        .cout_o (carry_w)
    );

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            ovf_q    <= 1'b0;
            upd_q    <= 1'b0;
        end else begin
            upd_q <= latch_w;
            if (latch_w) begin
                result_q <= sum_w;
                ovf_q    <= snap_ovf_w | carry_w;
            end
        end
    end

    fc_scan_display #(.NDIG(NDIG), .SCAN_DIV(SCAN_DIV)) u_scan (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .value_i   (result_q),
        .seg_o     (seg),
        .dig_sel_o (dig_sel)
    );

    assign result_bcd = result_q;
    assign ovf        = ovf_q;
    assign upd        = upd_q;

endmodule

// File: rtl/fc_freq_meter_chk.sv
module fc_freq_meter_chk #(
    parameter int NDIG     = 6,
    parameter int GATE_CYC = 10000,
    parameter int WAIT_CYC = 1250
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gate,
    input logic              upd,
    input logic [NDIG*4-1:0] result,
    input logic              ovf,
    input logic [NDIG-1:0]   dig_sel,
    input logic [6:0]        seg
);

    logic [31:0] hi_len, lo_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len <= '0;
            lo_len <= '0;
        end else begin
            hi_len <= gate ? hi_len + 1 : '0;
            lo_len <= gate ? '0 : lo_len + 1;
        end
    end

    p_gate_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate) |-> hi_len == GATE_CYC);

    p_gate_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> lo_len <= WAIT_CYC + 1);

    p_result_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |-> $stable(result));

    p_upd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd);

    p_ovf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |-> $stable(ovf));

    p_scan_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dig_sel) == 1);

    p_low_digit_lit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dig_sel[0] |-> seg != 7'h00);

endmodule

bind fc_freq_meter fc_freq_meter_chk #(
    .NDIG(NDIG), .GATE_CYC(GATE_CYC), .WAIT_CYC(WAIT_CYC)
) u_chk (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .gate    (gate_w),
    .upd     (upd),
    .result  (result_bcd),
    .ovf     (ovf),
    .dig_sel (dig_sel),
    .seg     (seg)
);

// File: tb/fc_freq_meter_bench.sv
module fc_freq_meter_bench;

    localparam int NDIG    = 4;
    localparam int REF_HZ  = 200_000_000;
    localparam int RES_HZ  = 100_000;
    localparam int SCAN_HZ = 25_000_000;
    localparam int GATE    = REF_HZ / RES_HZ;   // 2000
    localparam int SCAN    = REF_HZ / SCAN_HZ;  // 8
    localparam int WAITC   = GATE / 8;          // 250
    localparam int LIM     = 10 ** NDIG;
    localparam int TPER    = 10;                // reference period in time units (200 MHz)

    logic              clk, rst_n, sig;
    logic [NDIG*4-1:0] offset_bcd;
    logic [6:0]        seg;
    logic [NDIG-1:0]   dig_sel;
    logic [NDIG*4-1:0] result_bcd;
    logic              ovf, upd;

    int total = 0;
    int bad   = 0;
    int nclk  = 0;
    int updc  = 0;
    int last_upd = -1;
    int sig_per  = 0;
    bit done = 0;

    fc_freq_meter #(.NDIG(NDIG), .REF_HZ(REF_HZ), .RES_HZ(RES_HZ), .SCAN_HZ(SCAN_HZ)) u_fc_freq_meter (
        .ref_clk(clk), .rst_n(rst_n), .sig_in(sig), .offset_bcd(offset_bcd),
        .seg(seg), .dig_sel(dig_sel), .result_bcd(result_bcd), .ovf(ovf), .upd(upd)
    );

    initial begin
        clk = 1'b0;
        forever #(TPER/2) clk = ~clk;   // rising edges at odd times
    end

    // Signal source: rising edges always at even times.
    initial begin
        sig = 1'b0;
        #2;
        forever begin
            if (sig_per == 0) begin
                sig = 1'b0;
                #2;
            end else begin
                sig = 1'b1;
                #(sig_per/2);
                sig = 1'b0;
                #(sig_per/2);
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NDIG*4-1:0] to_bcd(input int v);
        logic [NDIG*4-1:0] r;
        int x;
        x = v;
        for (int i = 0; i < NDIG; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    function automatic logic [6:0] pattern(input logic [3:0] d);
        logic [6:0] p;
        case (d)
            4'd0: p = 7'h3F; 4'd1: p = 7'h06; 4'd2: p = 7'h5B; 4'd3: p = 7'h4F;
            4'd4: p = 7'h66; 4'd5: p = 7'h6D; 4'd6: p = 7'h7D; 4'd7: p = 7'h07;
            4'd8: p = 7'h7F; 4'd9: p = 7'h6F; default: p = 7'h00;
        endcase
        return p;
    endfunction

    always @(posedge clk) if (rst_n) nclk++;

    // Reference model of the display and the update cadence, every cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int idx;
            bit zero_up;
            logic [6:0] exp_seg;
            idx = (nclk / SCAN) % NDIG;
            chk("R6", "dig_sel", 64'(dig_sel), 64'(NDIG'(1) << idx));
            zero_up = 1'b1;
            for (int k = idx; k < NDIG; k++)
                if (result_bcd[4*k +: 4] != 4'd0) zero_up = 1'b0;
            exp_seg = (idx > 0 && zero_up) ? 7'h00 : pattern(result_bcd[4*idx +: 4]);
            chk(idx > 0 && zero_up ? "R8" : "R7", "seg", 64'(seg), 64'(exp_seg));
            if (upd) begin
                if (last_upd >= 0) begin
                    int gap;
                    gap = nclk - last_upd;
                    chk("R10", "update gap in range", 64'((gap >= GATE + 2) && (gap <= GATE + WAITC + 1)), 64'(1));
                end
                last_upd = nclk;
                updc++;
            end
        end
    end

    // Apply a period and offset, skip two readings, check the next two.
    task automatic measure(input int per, input int off, input string req);
        int cnt, stored, tot, base;
        bit chain_ovf, exp_ovf;
        sig_per    = per;
        offset_bcd = to_bcd(off);
        cnt        = (per == 0) ? 0 : (GATE * TPER) / per;
        chain_ovf  = (cnt >= LIM);
        stored     = cnt % LIM;
        tot        = stored + off;
        exp_ovf    = chain_ovf || (tot >= LIM);
        base       = updc;
        for (int k = 0; k < 2; k++) begin
            wait (updc == base + 3 + k);
            chk(req, "result_bcd", 64'(result_bcd), 64'(to_bcd(tot % LIM)));
            chk("R4", "ovf", 64'(ovf), 64'(exp_ovf));
        end
    endtask

    initial begin
        rst_n      = 1'b0;
        offset_bcd = '0;
        repeat (4) @(negedge clk);
        // R9: reset state
        chk("R9", "result in reset", 64'(result_bcd), 64'(0));
        chk("R9", "ovf in reset", 64'(ovf), 64'(0));
        chk("R9", "upd in reset", 64'(upd), 64'(0));
        chk("R9", "dig_sel in reset", 64'(dig_sel), 64'(1));
        rst_n = 1'b1;

        measure(40,  0,    "R1");   // 500, top digit blanked
        measure(16,  0,    "R1");   // 1250
        measure(8,   1234, "R3");   // 2500 + 1234 = 3734
        measure(400, 0,    "R8");   // 50, two leading blanks
        measure(2,   0,    "R4");   // 10000: chain carries out -> 0000, ovf
        measure(20,  9500, "R4");   // 1000 + 9500 -> 0500, ovf
        measure(0,   0,    "R5");   // no edges -> 0000
        measure(0,   42,   "R5");   // no edges -> offset only
        measure(20,  0,    "R2");   // recovery: 1000

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R2 watchdog expired actual=updc%0d expected=progress", updc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule